// File: doc/BRIEF.md
# I/O Space Address Router

This block steers I/O-space requests to their destination. It holds a small set of programmable windows, four by default. Each window has a lower and an upper boundary on 25-bit I/O addresses, in 4 KB steps. It also has separate read and write permissions and names a destination node and link. A request gives an address and a direction. One cycle later the router answers with a hit flag, the destination node and link, and the index of the window that claimed the request.

Each window can also apply two legacy rules. The display-port rule claims the fixed text and graphics adapter port ranges below 64 KB, whatever the window's boundaries are. The alias-filter rule stops the window from claiming any address below 64 KB that falls in the upper three quarters of a 1 KB block, where old expansion cards decode only ten address bits. A plain register write port loads the window settings.

Top module: `io_space_router`

## Requirements
- R1: During reset and on the first cycle after it, rsp_valid is low. After reset every window is disabled, so every request misses until software programs a window.
- R2: A configuration write with cfg_addr = 0xC0 + 8*i loads the boundary register of window i. A write with cfg_addr = 0xC4 + 8*i loads the destination register of window i. Writes to any other offset, including offsets that are not multiples of 4, change nothing.
- R3: Both registers keep their boundary in wdata[24:12]. A request matches window i on range when base <= req_addr[24:12] <= limit, with both bounds inclusive.
- R4: Boundary register bit 0 allows reads and bit 1 allows writes. A request whose direction is not allowed never hits that window.
- R5: With boundary register bit 4 set, a request with req_addr < 0x10000 and req_addr[9:0] in 0x3B0..0x3BB or 0x3C0..0x3DF hits the window, whatever its bounds are. The alias filter does not suppress this match.
- R6: With boundary register bit 5 set, a range match with req_addr < 0x10000 and req_addr[9:8] != 00 is suppressed. Addresses at 0x10000 and above are not filtered.
- R7: The destination register gives the node in wdata[2:0] and the link in wdata[5:4]. On a hit, rsp_node and rsp_link carry these fields of the winning window.
- R8: A window whose link field is 11 never hits.
- R9: A display-port match is also gated by the window's read and write permissions.
- R10: When several windows hit, the lowest index wins and rsp_pair reports that index.
- R11: On a miss, rsp_hit is low and rsp_node, rsp_link and rsp_pair are all zero.
- R12: Every request with req_valid high produces exactly one response with rsp_valid high on the following cycle. Back-to-back requests are accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 25 | Request I/O address |
| req_is_write | input | 1 | 1 = write request, 0 = read request |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | A window claimed the request |
| rsp_node | output | 3 | Destination node of the winning window |
| rsp_link | output | 2 | Destination link of the winning window |
| rsp_pair | output | 2 | Index of the winning window |

## Verification
Assertions check four things on every cycle: the one-cycle response timing, the zeroed fields on a miss, that the chosen window really hit and that no lower window did, and that a window's hit never comes from a disallowed direction or a reserved link code. Only the bench's scenarios can show the rest, because it depends on values. These are the exact boundary edges, the display-port and alias-filter windows, the effect of the 64 KB cut-off, and the fact that writes to undecoded offsets leave the routing unchanged.

// File: rtl/io_route_pkg.sv
package io_route_pkg;

  localparam int ADDR_W  = 25;
  localparam int BND_LSB = 12;
  localparam int BND_W   = ADDR_W - BND_LSB;
  localparam logic [1:0] LINK_RSVD = 2'b11;

  typedef struct packed {
    logic             rd_ok;
    logic             wr_ok;
    logic             vga_on;
    logic             isa_on;
    logic [BND_W-1:0] lo;
  } win_base_t;

  typedef struct packed {
    logic [2:0]       node;
    logic [1:0]       link;
    logic [BND_W-1:0] hi;
  } win_dest_t;

  // Address lies in the legacy 64 KB region.
  function automatic logic low_64k(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:16] == '0;
  endfunction

  // Standard display adapter port windows (ten-bit decode).
  function automatic logic display_port(input logic [ADDR_W-1:0] a);
    logic [9:0] p;
    p = a[9:0];
    return low_64k(a) &&
           (((p >= 10'h3B0) && (p <= 10'h3BB)) ||
            ((p >= 10'h3C0) && (p <= 10'h3DF)));
  endfunction

  // Upper 768 bytes of a 1 KB block below 64 KB.
  function automatic logic alias_zone(input logic [ADDR_W-1:0] a);
    return low_64k(a) && (a[9:8] != 2'b00);
  endfunction

  // Inclusive page compare on the boundary bits.
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [BND_W-1:0]  lo,
                                     input logic [BND_W-1:0]  hi);
    return (a[ADDR_W-1:BND_LSB] >= lo) && (a[ADDR_W-1:BND_LSB] <= hi);
  endfunction

endpackage

// File: rtl/io_route_regs.sv
module io_route_regs
  import io_route_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int CFG_AW    = 8,
  parameter int WIN_BASE  = 'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output win_base_t         base_q [NUM_PAIRS],
  output win_dest_t         dest_q [NUM_PAIRS]
);

  localparam int SPAN = 8 * NUM_PAIRS;

  logic [CFG_AW-1:0] rel;
  logic              in_span;
  logic              aligned;
  logic [NUM_PAIRS-1:0] base_we;
  logic [NUM_PAIRS-1:0] dest_we;

  assign rel     = addr - CFG_AW'(WIN_BASE);
  assign in_span = (addr >= CFG_AW'(WIN_BASE)) && (int'(rel) < SPAN);
  assign aligned = addr[1:0] == 2'b00;

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    assign base_we[i] = wr_en && in_span && aligned &&
                        (int'(rel[CFG_AW-1:3]) == i) && !rel[2];
    assign dest_we[i] = wr_en && in_span && aligned &&
                        (int'(rel[CFG_AW-1:3]) == i) && rel[2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        dest_q[i] <= '0;
      end else begin
        if (base_we[i]) begin
          base_q[i].rd_ok  <= wdata[0];
          base_q[i].wr_ok  <= wdata[1];
          base_q[i].vga_on <= wdata[4];
          base_q[i].isa_on <= wdata[5];
          base_q[i].lo     <= wdata[ADDR_W-1:BND_LSB];
        end
        if (dest_we[i]) begin
          dest_q[i].node <= wdata[2:0];
          dest_q[i].link <= wdata[5:4];
          dest_q[i].hi   <= wdata[ADDR_W-1:BND_LSB];
        end
      end
    end

    AST_BASE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      base_we[i] |=> (base_q[i].lo == $past(wdata[ADDR_W-1:BND_LSB])))
      else $error("boundary field not loaded"); // R2
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({base_we, dest_we}))
    else $error("config write hit two registers"); // R2

  AST_MISALIGNED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!aligned || !in_span) |-> ({base_we, dest_we} == '0))
    else $error("undecoded offset wrote a register"); // R2

endmodule

// File: rtl/io_route_match.sv
module io_route_match
  import io_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  win_base_t         base,
  input  win_dest_t         dest,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  output logic              hit
);

  logic dir_ok;
  logic link_ok;
  logic range_hit;
  logic alias_block;
  logic vga_hit;

  assign dir_ok      = is_write ? base.wr_ok : base.rd_ok;
  assign link_ok     = dest.link != LINK_RSVD;
  assign range_hit   = in_window(addr, base.lo, dest.hi);
  assign alias_block = base.isa_on && alias_zone(addr);
  assign vga_hit     = base.vga_on && display_port(addr);

  assign hit = dir_ok && link_ok && ((range_hit && !alias_block) || vga_hit);

  AST_NO_RSVD_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (dest.link != 2'b11))
    else $error("reserved link produced a hit"); // R8

  AST_DIR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (is_write ? base.wr_ok : base.rd_ok))
    else $error("hit on disallowed direction"); // R4

  AST_ALIAS_ONLY_VGA: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && alias_block) |-> vga_hit)
    else $error("alias filter bypassed"); // R6

endmodule

// File: rtl/io_route_pick.sv
module io_route_pick #(
  parameter int NUM_PAIRS = 4,
  localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PAIRS-1:0] hits,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_PAIRS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  logic [NUM_PAIRS-1:0] below_mask;
  assign below_mask = (NUM_PAIRS'(1) << idx) - NUM_PAIRS'(1);

  AST_WINNER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> hits[idx])
    else $error("winner did not hit"); // R10

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((hits & below_mask) == '0))
    else $error("lower window skipped"); // R10

  AST_ANY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    any == (hits != '0))
    else $error("hit summary mismatch"); // R11

endmodule

// File: rtl/io_space_router.sv
module io_space_router
  import io_route_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int CFG_AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [24:0]       req_addr,
  input  logic              req_is_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [2:0]        rsp_node,
  output logic [1:0]        rsp_link,
  output logic [1:0]        rsp_pair
);

  localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;

  win_base_t            base_q [NUM_PAIRS];
  win_dest_t            dest_q [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] pair_hit;
  logic                 any_hit;
  logic [IDX_W-1:0]     win_idx;

  io_route_regs #(.NUM_PAIRS(NUM_PAIRS), .CFG_AW(CFG_AW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .base_q (base_q),
    .dest_q (dest_q)
  );

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_match
    io_route_match u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .base     (base_q[i]),
      .dest     (dest_q[i]),
      .addr     (req_addr),
      .is_write (req_is_write),
      .hit      (pair_hit[i])
    );
  end

  io_route_pick #(.NUM_PAIRS(NUM_PAIRS)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .hits  (pair_hit),
    .any   (any_hit),
    .idx   (win_idx)
  );

  logic       take_hit;
  logic [2:0] sel_node;
  logic [1:0] sel_link;

  assign take_hit = req_valid && any_hit;
  assign sel_node = take_hit ? dest_q[win_idx].node : 3'd0;
  assign sel_link = take_hit ? dest_q[win_idx].link : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_node  <= '0;
      rsp_link  <= '0;
      rsp_pair  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= take_hit;
      rsp_node  <= sel_node;
      rsp_link  <= sel_link;
      rsp_pair  <= take_hit ? 2'(win_idx) : 2'd0;
    end
  end

  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rsp_valid == $past(req_valid)))
    else $error("response not one cycle after request"); // R12

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_node == 3'd0 && rsp_link == 2'd0 && rsp_pair == 2'd0))
    else $error("miss with nonzero fields"); // R11

  AST_HIT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid)
    else $error("hit without response"); // R12

  AST_HIT_LINK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_link != 2'b11))
    else $error("reserved link routed"); // R8

endmodule

// File: tb/sim_io_space_router.sv
module sim_io_space_router;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [24:0] req_addr = '0;
  logic        req_is_write = 1'b0;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_node;
  logic [1:0]  rsp_link, rsp_pair;

  always #(CLK_PERIOD / 2) clk = ~clk;

  io_space_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_write(req_is_write), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_node(rsp_node), .rsp_link(rsp_link), .rsp_pair(rsp_pair)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Shadow of the programmed windows.
  logic [31:0] sh_base [4];
  logic [31:0] sh_dest [4];

  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference route: {hit, node[2:0], link[1:0], pair[1:0]}.
  function automatic logic [7:0] model(input int unsigned a, input bit wr);
    for (int p = 0; p < 4; p++) begin
      bit en, low, vga, blk, rng;
      int unsigned lo_b, hi_b, a10;
      en   = wr ? sh_base[p][1] : sh_base[p][0];
      if (!en || sh_dest[p][5:4] == 2'b11) continue;
      low  = a < 32'h10000;
      a10  = a % 1024;
      vga  = sh_base[p][4] && low &&
             ((a10 >= 'h3B0 && a10 < 'h3BC) || (a10 >= 'h3C0 && a10 < 'h3E0));
      blk  = sh_base[p][5] && low && (a10 >= 256);
      lo_b = (sh_base[p] & 32'h01FF_F000);
      hi_b = (sh_dest[p] & 32'h01FF_F000) + 32'hFFF;
      rng  = (a >= lo_b) && (a <= hi_b);
      if (vga || (rng && !blk))
        return {1'b1, sh_dest[p][2:0], sh_dest[p][5:4], 2'(p)};
    end
    return 8'h00;
  endfunction

  task automatic cfg_write(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = off; cfg_wdata = d;
    if (off >= 8'hC0 && off < 8'hE0 && off[1:0] == 2'b00) begin
      if (off[2]) sh_dest[(off - 8'hC0) / 8] = d;
      else        sh_base[(off - 8'hC0) / 8] = d;
    end
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // Driver: presents a request and pushes its expected response.
  task automatic send(input int unsigned a, input bit wr, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 25'(a); req_is_write = wr;
    exp_q.push_back(model(a, wr));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops and compares on each response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected response", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {rsp_hit, rsp_node, rsp_link, rsp_pair}, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 4; p++) begin sh_base[p] = '0; sh_dest[p] = '0; end
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", rsp_valid, 0);
    send('h1000, 0, "R1 miss when unprogrammed");
    idle(1);

    // Window 0: 0x1000..0x3FFF, read only, node 5 link 1.
    cfg_write(8'hC4, 32'h0000_3015);
    cfg_write(8'hC0, 32'h0000_1001);
    send('h1000, 0, "R3 lower edge");
    send('h3FFF, 0, "R3 upper edge");
    send('h4000, 0, "R3 above upper");
    send('h0FFF, 0, "R3 below lower");
    send('h2000, 1, "R4 write blocked");
    idle(1);

    // Window 1: 0x2000..0x2FFF, read/write, node 2 link 2.
    cfg_write(8'hCC, 32'h0000_2022);
    cfg_write(8'hC8, 32'h0000_2003);
    send('h2000, 0, "R10 lowest wins");
    send('h2000, 1, "R7 node/link of window 1");
    idle(1);

    // Window 2: reserved link covering 0x8000.
    cfg_write(8'hD4, 32'h0000_8036);
    cfg_write(8'hD0, 32'h0000_8003);
    send('h8000, 0, "R8 reserved link never hits");
    idle(1);

    // Window 3: high range plus display ports, node 7 link 0.
    cfg_write(8'hDC, 32'h0010_0007);
    cfg_write(8'hD8, 32'h0010_0013);
    send('h03B0, 0, "R5 display low edge");
    send('h03BB, 0, "R5 display first window end");
    send('h03BC, 0, "R5 display gap");
    send('h03DF, 0, "R5 display upper edge");
    send('h53C0, 0, "R5 display aliased 1K block");
    send('h103C0, 0, "R5 display above 64K");
    send('h100800, 1, "R3 window 3 range");
    idle(1);

    // Alias filter on window 1 and on window 3.
    cfg_write(8'hC8, 32'h0000_2023);
    send('h2000, 1, "R6 block offset 0 passes");
    send('h2100, 1, "R6 upper 768 blocked");
    send('h23FF, 1, "R6 block end blocked");
    send('h2400, 1, "R6 next block passes");
    idle(1);
    cfg_write(8'hDC, 32'h0001_0007);
    cfg_write(8'hD8, 32'h0001_0033);
    send('h10100, 1, "R6 no filter above 64K");
    send('h03B0, 1, "R5 display wins over filter");
    idle(1);

    // Display match gated by direction.
    cfg_write(8'hD8, 32'h0001_0012);
    send('h03C5, 0, "R9 display read disabled");
    send('h03C5, 1, "R9 display write allowed");
    idle(1);

    // Undecoded offsets change nothing.
    cfg_write(8'hC2, 32'hFFFF_FFFF);
    cfg_write(8'hE0, 32'hFFFF_FFFF);
    cfg_write(8'hBC, 32'hFFFF_FFFF);
    cfg_write(8'hC9, 32'h0000_0000);
    send('h2000, 0, "R2 offsets ignored window 0");
    send('h2000, 1, "R2 offsets ignored window 1");
    send('h1FFFFFF, 1, "R2 offsets ignored top address");
    idle(3);

    check("R12 all responses seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule